// File: doc/BRIEF.md
# Programmable Interval Timer with Byte-Wide Preset Access

This block is a down-counting interval timer that sits on a simple I/O bus with byte and halfword transfers. Software builds a 16-bit preset in a holding buffer. The upper nibble of the preset picks a time base and the lower twelve bits give a count. A start command moves the preset into the active registers and starts counting. The preset can be written whole, or as two bytes in sequence with the high byte first.

At each terminal count the timer reloads itself from the holding buffer. Software can therefore queue a new interval, or a new time base, while the current one is still running. If software has written only half of a two-byte preset when a reload happens, the block records an overflow condition. A sense-status transfer reports that condition and clears it.

The only timing input is a single pulse every microsecond. An internal chain of decade prescalers derives the 10 µs, 100 µs and 1 ms steps. The current count can be read back a byte at a time or as one halfword. Interrupt arming and enabling are controlled by fields in the command byte.

Top module: `pit_timer`

## Requirements
- R1: While reset is asserted, and on the cycle after it, `rdata` is 0 and `irq` is 0. After reset, a halfword read of the count returns 0 and a sense-status read returns 0.
- R2: A byte write stores `wdata[7:0]` into bits 15:8 of the buffer when the write pointer is clear and into bits 7:0 when it is set, then toggles the pointer. A halfword write stores all 16 bits and clears the pointer.
- R3: A halfword read returns the 12-bit current count zero-extended to 16 bits and clears the read pointer. A byte read returns count bits 11:8 (zero-extended) when the read pointer is clear and bits 7:0 when it is set, then toggles the pointer. Read data appears on `rdata` in the cycle after the strobe.
- R4: A command with `cmd_data[5]` set loads the active preset from the buffer and loads the current count from buffer bits 11:0. It also clears the overflow flag and both byte pointers. Counting starts only if buffer bits 15:12 are nonzero. Microsecond pulses in the start cycle itself are not counted.
- R5: The time base is chosen by the lowest set bit of the active rate field: bit 12 gives 1 µs, bit 13 gives 10 µs, bit 14 gives 100 µs and bit 15 gives 1 ms per decrement.
- R6: While running, each time-base step lowers the count by one. The step that would bring the count to zero is the terminal count. At the terminal count the block sets the interrupt request if armed and reloads the active preset and the current count from the buffer.
- R7: A reload whose rate field is zero stops the timer, and the count then stays fixed whatever pulses arrive.
- R8: If the write pointer is set at a terminal count, the overflow flag is set. A sense-status read returns 16'h0008 and clears both the flag and the interrupt request when the flag is set. Otherwise it returns 0 and changes nothing.
- R9: Command bits 7:6 control interrupts: 01 arms and enables, 10 disarms and disables, 11 arms with the interrupt disabled, and 00 leaves both unchanged. `irq` is the request ANDed with the enable.
- R10: A loaded count of zero behaves as a count of one: the terminal count comes one time-base step after loading.
- R11: The decade prescaler restarts on every start command and every reload, so the first step of a slow time base comes a full period after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| wr_byte | input | 1 | Byte write strobe (data on `wdata[7:0]`) |
| wr_half | input | 1 | Halfword write strobe |
| wdata | input | 16 | Write data |
| rd_byte | input | 1 | Byte read strobe for the current count |
| rd_half | input | 1 | Halfword read strobe for the current count |
| sense_stb | input | 1 | Sense-status strobe |
| cmd_stb | input | 1 | Output-command strobe |
| cmd_data | input | 3 | Command bits 7:5 (7:6 interrupt control, 5 start) |
| rdata | output | 16 | Registered read / status data |
| irq | output | 1 | Interrupt request, gated by the enable |

## Verification
A wrong count or a wrong time-base choice shows up at the first readback of the count. It also shifts the interrupt edge by whole pulses, so a test that reads the count one pulse before the expected terminal count and again right after it pins the error to a single step. A stale byte pointer shows up on the very next byte read as the wrong half of the count, or after the next start as a preset with swapped bytes. A missed overflow shows up as a zero status on the sense read that follows the reload, and a prescaler that fails to restart moves the first slow step early by the number of pulses counted before the restart.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 12;
    localparam int RATE_W = DATA_W - CNT_W;
    localparam int NBASE  = RATE_W;

    localparam logic [DATA_W-1:0] STATUS_OVF = 16'h0008;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [CNT_W-1:0]  count;
    } preset_t;

    typedef enum logic [1:0] {
        ICTL_KEEP   = 2'b00,
        ICTL_ARM_EN = 2'b01,
        ICTL_DISARM = 2'b10,
        ICTL_ARM    = 2'b11
    } ictl_e;

    // index of the lowest set rate bit; zero when the field is empty
    function automatic logic [1:0] base_of(input logic [RATE_W-1:0] rate);
        logic [1:0] idx;
        idx = 2'd0;
        for (int i = RATE_W - 1; i >= 0; i--) begin
            if (rate[i]) idx = 2'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
    parameter int DIV    = 10,
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              tick_us,
    output logic [STAGES:0]   step
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [STAGES:0] carry;
    assign carry[0] = tick_us;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [DW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst || restart)
                cnt <= '0;
            else if (carry[g])
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
        assign carry[g+1] = carry[g] && (cnt == LAST);
    end

    assign step = carry;
endmodule

// File: rtl/pit_bufport.sv
module pit_bufport
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_byte,
    input  logic              wr_half,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_byte,
    input  logic              rd_half,
    input  logic              sense_stb,
    input  logic              clr_ptrs,
    input  logic              ovf,
    input  logic [CNT_W-1:0]  cur_count,
    output preset_t           buf_q,
    output logic              wptr,
    output logic [DATA_W-1:0] rdata
);
    logic rptr;
    logic [DATA_W-1:0] count_ext;

    assign count_ext = {{RATE_W{1'b0}}, cur_count};

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            wptr  <= 1'b0;
        end else begin
            if (wr_half) begin
                buf_q <= preset_t'(wdata);
                wptr  <= 1'b0;
            end else if (wr_byte) begin
                if (wptr) buf_q[7:0]  <= wdata[7:0];
                else      buf_q[15:8] <= wdata[7:0];
                wptr <= ~wptr;
            end
            if (clr_ptrs) wptr <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr  <= 1'b0;
            rdata <= '0;
        end else begin
            if (rd_half) begin
                rdata <= count_ext;
                rptr  <= 1'b0;
            end else if (rd_byte) begin
                rdata <= rptr ? {8'h00, count_ext[7:0]} : {8'h00, count_ext[15:8]};
                rptr  <= ~rptr;
            end else if (sense_stb) begin
                rdata <= ovf ? STATUS_OVF : '0;
            end
            if (clr_ptrs) rptr <= 1'b0;
        end
    end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ictl_vld,
    input  ictl_e             ictl,
    input  logic              sense_stb,
    input  preset_t           buf_q,
    input  logic              wptr,
    input  logic [NBASE-1:0]  step,
    output logic [CNT_W-1:0]  ccount,
    output logic              running,
    output logic              terminal,
    output logic              sel_step,
    output logic              ovf,
    output logic              int_en,
    output logic              irq
);
    preset_t active;
    logic    arm, req;

    assign sel_step = step[base_of(active.rate)];
    assign terminal = running && !start && sel_step && (ccount <= CNT_W'(1));
    assign irq      = req && int_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= '0;
            ccount  <= '0;
            running <= 1'b0;
        end else if (start || terminal) begin
            active  <= buf_q;
            ccount  <= buf_q.count;
            running <= (buf_q.rate != '0);
        end else if (running && sel_step) begin
            ccount  <= ccount - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm    <= 1'b0;
            int_en <= 1'b0;
        end else if (ictl_vld) begin
            case (ictl)
                ICTL_ARM_EN: begin arm <= 1'b1; int_en <= 1'b1; end
                ICTL_DISARM: begin arm <= 1'b0; int_en <= 1'b0; end
                ICTL_ARM:    begin arm <= 1'b1; int_en <= 1'b0; end
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
            req <= 1'b0;
        end else begin
            if (sense_stb && ovf) begin
                ovf <= 1'b0;
                req <= 1'b0;
            end
            if (start) ovf <= 1'b0;
            if (terminal) begin
                if (wptr) ovf <= 1'b1;
                if (arm)  req <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_us,
    input  logic              wr_byte,
    input  logic              wr_half,
    input  logic [15:0]       wdata,
    input  logic              rd_byte,
    input  logic              rd_half,
    input  logic              sense_stb,
    input  logic              cmd_stb,
    input  logic [7:5]        cmd_data,
    output logic [15:0]       rdata,
    output logic              irq
);
    logic             cmd_start;
    logic             restart;
    logic [NBASE-1:0] step;
    preset_t          buf_q;
    logic             wptr;
    logic [CNT_W-1:0] ccount;
    logic             running, terminal, sel_step, ovf, int_en;
    ictl_e            ictl;

    assign cmd_start = cmd_stb && cmd_data[5];
    assign ictl      = ictl_e'(cmd_data[7:6]);
    assign restart   = cmd_start || terminal;

    pit_prescale #(.DIV(10), .STAGES(NBASE - 1)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick_us (tick_us),
        .step    (step)
    );

    pit_bufport u_port (
        .clk       (clk),
        .rst       (rst),
        .wr_byte   (wr_byte),
        .wr_half   (wr_half),
        .wdata     (wdata),
        .rd_byte   (rd_byte),
        .rd_half   (rd_half),
        .sense_stb (sense_stb),
        .clr_ptrs  (cmd_start),
        .ovf       (ovf),
        .cur_count (ccount),
        .buf_q     (buf_q),
        .wptr      (wptr),
        .rdata     (rdata)
    );

    pit_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_start),
        .ictl_vld  (cmd_stb),
        .ictl      (ictl),
        .sense_stb (sense_stb),
        .buf_q     (buf_q),
        .wptr      (wptr),
        .step      (step),
        .ccount    (ccount),
        .running   (running),
        .terminal  (terminal),
        .sel_step  (sel_step),
        .ovf       (ovf),
        .int_en    (int_en),
        .irq       (irq)
    );
endmodule

// File: rtl/pit_checker.sv
module pit_checker (
    input logic        clk,
    input logic        rst,
    input logic        irq,
    input logic [15:0] rdata,
    input logic        cmd_stb,
    input logic [7:5]  cmd_data,
    input logic        sense_stb,
    input logic        running,
    input logic        sel_step,
    input logic        terminal,
    input logic        ovf,
    input logic [11:0] ccount,
    input logic [11:0] buf_count
);
    logic start;
    assign start = cmd_stb && cmd_data[5];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (rdata == 16'h0000) && !irq); // R1

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        start |=> (ccount == $past(buf_count)) && !ovf); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        running && sel_step && !start && !terminal |=> ccount == $past(ccount) - 12'd1); // R6

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !running && !start |=> $stable(ccount)); // R7

    AST_SENSE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sense_stb && ovf && !terminal |=> !ovf && !irq && rdata == 16'h0008); // R8

    AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (rst)
        cmd_stb && cmd_data[7:6] == 2'b10 |=> !irq); // R9
endmodule

bind pit_timer pit_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .rdata     (rdata),
    .cmd_stb   (cmd_stb),
    .cmd_data  (cmd_data),
    .sense_stb (sense_stb),
    .running   (running),
    .sel_step  (sel_step),
    .terminal  (terminal),
    .ovf       (ovf),
    .ccount    (ccount),
    .buf_count (buf_q.count)
);

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_us = 1'b0;
    logic        wr_byte = 1'b0, wr_half = 1'b0;
    logic [15:0] wdata = '0;
    logic        rd_byte = 1'b0, rd_half = 1'b0, sense_stb = 1'b0;
    logic        cmd_stb = 1'b0;
    logic [7:5]  cmd_data = '0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pit_timer dut (
        .clk(clk), .rst(rst), .tick_us(tick_us),
        .wr_byte(wr_byte), .wr_half(wr_half), .wdata(wdata),
        .rd_byte(rd_byte), .rd_half(rd_half), .sense_stb(sense_stb),
        .cmd_stb(cmd_stb), .cmd_data(cmd_data),
        .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] b);
        @(negedge clk) begin wr_byte = 1'b1; wdata = {8'h00, b}; end
        @(negedge clk) wr_byte = 1'b0;
    endtask

    task automatic whalf(input logic [15:0] h);
        @(negedge clk) begin wr_half = 1'b1; wdata = h; end
        @(negedge clk) wr_half = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);
        @(negedge clk) begin cmd_stb = 1'b1; cmd_data = c[7:5]; end
        @(negedge clk) cmd_stb = 1'b0;
    endtask

    task automatic rhalf(output logic [15:0] v);
        @(negedge clk) rd_half = 1'b1;
        @(negedge clk) begin rd_half = 1'b0; v = rdata; end
    endtask

    task automatic rbyte(output logic [15:0] v);
        @(negedge clk) rd_byte = 1'b1;
        @(negedge clk) begin rd_byte = 1'b0; v = rdata; end
    endtask

    task automatic sense(output logic [15:0] v);
        @(negedge clk) sense_stb = 1'b1;
        @(negedge clk) begin sense_stb = 1'b0; v = rdata; end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_us = 1'b1;
            @(negedge clk) tick_us = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        chk("R1 rdata in reset", rdata, 16'h0000);
        chk("R1 irq in reset", {15'd0, irq}, 16'h0000);
        @(negedge clk) rst = 1'b0;
        rhalf(v);  chk("R1 count after reset", v, 16'h0000);
        sense(v);  chk("R1 status after reset", v, 16'h0000);
    endtask

    task automatic t_bytes();
        logic [15:0] v;
        do_reset();
        wbyte(8'h0A); wbyte(8'hBC);
        cmd(8'h20);
        rhalf(v); chk("R2 byte write order / R4 load", v, 16'h0ABC);
        rbyte(v); chk("R3 first byte read high", v, 16'h000A);
        rbyte(v); chk("R3 second byte read low", v, 16'h00BC);
        rbyte(v); chk("R3 pointer wraps to high", v, 16'h000A);
        rhalf(v); chk("R3 halfword read", v, 16'h0ABC);
        rbyte(v); chk("R3 halfword read clears pointer", v, 16'h000A);
        ticks(3);
        rhalf(v); chk("R4 zero rate does not run", v, 16'h0ABC);
        wbyte(8'h12);
        whalf(16'h0345);
        wbyte(8'h01); wbyte(8'h02);
        cmd(8'h20);
        rhalf(v); chk("R2 halfword write clears pointer", v, 16'h0102);
    endtask

    task automatic t_run_1us();
        logic [15:0] v;
        do_reset();
        whalf(16'h1005);
        cmd(8'h60);
        ticks(4);
        rhalf(v); chk("R6 count after 4 steps", v, 16'h0001);
        chk("R6 no irq before terminal", {15'd0, irq}, 16'h0000);
        ticks(1);
        chk("R6 irq at terminal", {15'd0, irq}, 16'h0001);
        rhalf(v); chk("R6 reload from buffer", v, 16'h0005);
        sense(v); chk("R8 status zero without overflow", v, 16'h0000);
        chk("R8 irq kept without overflow", {15'd0, irq}, 16'h0001);
        // half-written preset at terminal: high byte 00, low byte stays 05
        wbyte(8'h00);
        ticks(5);
        rhalf(v); chk("R7 reload with zero rate", v, 16'h0005);
        ticks(4);
        rhalf(v); chk("R7 stopped count holds", v, 16'h0005);
        sense(v); chk("R8 overflow status", v, 16'h0008);
        chk("R8 sense clears irq", {15'd0, irq}, 16'h0000);
        sense(v); chk("R8 overflow cleared", v, 16'h0000);
    endtask

    task automatic t_intctl();
        logic [15:0] v;
        do_reset();
        cmd(8'h80);
        whalf(16'h1002);
        cmd(8'h20);
        ticks(2);
        chk("R9 disarmed no irq", {15'd0, irq}, 16'h0000);
        cmd(8'hC0);
        ticks(2);
        chk("R9 armed but disabled", {15'd0, irq}, 16'h0000);
        cmd(8'h40);
        chk("R9 enable exposes request", {15'd0, irq}, 16'h0001);
        cmd(8'h80);
        chk("R9 disarm masks irq", {15'd0, irq}, 16'h0000);
        rhalf(v); chk("R9 timer keeps running", v, 16'h0002);
    endtask

    task automatic t_rates();
        logic [15:0] v;
        do_reset();
        whalf(16'h3003);
        cmd(8'h60);
        ticks(2);
        rhalf(v); chk("R5 lowest bit picks 1us", v, 16'h0001);
        do_reset();
        whalf(16'h2002);
        cmd(8'h60);
        ticks(9);
        rhalf(v); chk("R5 10us before first step", v, 16'h0002);
        ticks(1);
        rhalf(v); chk("R5 10us first step", v, 16'h0001);
        ticks(10);
        chk("R5 10us terminal irq", {15'd0, irq}, 16'h0001);
        do_reset();
        whalf(16'h4001);
        cmd(8'h60);
        ticks(99);
        chk("R5 100us not yet", {15'd0, irq}, 16'h0000);
        ticks(1);
        chk("R5 100us terminal", {15'd0, irq}, 16'h0001);
        do_reset();
        whalf(16'h8002);
        cmd(8'h60);
        ticks(1999);
        rhalf(v); chk("R5 1ms count before terminal", v, 16'h0001);
        chk("R5 1ms no irq yet", {15'd0, irq}, 16'h0000);
        ticks(1);
        chk("R5 1ms terminal", {15'd0, irq}, 16'h0001);
    endtask

    task automatic t_zero_and_restart();
        logic [15:0] v;
        do_reset();
        whalf(16'h1000);
        cmd(8'h60);
        rhalf(v); chk("R10 zero count loads as zero", v, 16'h0000);
        ticks(1);
        chk("R10 zero count ends after one step", {15'd0, irq}, 16'h0001);
        do_reset();
        whalf(16'h2001);
        cmd(8'h60);
        ticks(7);
        cmd(8'h20);
        ticks(9);
        chk("R11 restart delays first step", {15'd0, irq}, 16'h0000);
        ticks(1);
        chk("R11 step after full period", {15'd0, irq}, 16'h0001);
        // reload also restarts: buffer changed to 10us count 1 with pending pulses
        do_reset();
        whalf(16'h1001);
        cmd(8'h60);
        whalf(16'h2001);
        ticks(1);
        rhalf(v); chk("R11 reload takes new rate", v, 16'h0001);
        sense(v);
        ticks(9);
        rhalf(v); chk("R11 no step before 10 pulses", v, 16'h0001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_bytes();
        t_run_1us();
        t_intctl();
        t_rates();
        t_zero_and_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule